// File: doc/BRIEF.md
# Line Alarm Interrupt Register Bank

This block gathers the line alarms of a two-channel line interface and exposes them through a small byte-wide register bus. Each channel has three alarm sources that can raise an interrupt: transmit inactivity, receive loss of signal and receive loss of lock. The transmit-inactivity alarm is produced inside the block. A monitor watches the positive and negative transmit monitor lines and declares the alarm once no bipolar pulse has been seen for 128 consecutive bit periods. One clock cycle is one bit period. The alarm clears as soon as a pulse shows up again.

Every channel owns an interrupt-enable register, a sticky interrupt-status register and a read-only alarm register. A status bit latches whenever its alarm changes state, in either direction, and it is cleared by reading the status register. The alarm register shows the live, registered alarm levels together with three further indications that are passed straight through: analog LOS, digital LOS and pattern-detector out of sync. A single active-high interrupt output is raised while any enabled status bit of either channel is set.

Bus accesses take one clock. Writes take effect at the clock edge where the write strobe is high. Read data is registered at the edge where the read strobe is high and stays on the data output until the next read.

Top module: `lair_alarm_bank`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is low.
- R2: Channel 0 registers sit at 0x01 (enable), 0x02 (status) and 0x03 (alarm), and channel 1 registers sit at 0x09, 0x0A and 0x0B. A read of any other address returns 0x00. Read data is on `bus_rdata` after the clock edge at which `bus_rd` is high.
- R3: In the enable register, bit 0 enables transmit inactivity, bit 1 enables receive LOS and bit 2 enables receive loss of lock. Bits 7..3 are not stored and read as 0, so writing 0xFF reads back 0x07.
- R4: A status bit (bit 0 inactivity, bit 1 receive LOS, bit 2 loss of lock, bits 7..3 zero) is set on a rise and also on a fall of its alarm. For an alarm input, the bit is set at the second clock edge after the input changes: the first edge registers the input and the second edge detects the change.
- R5: A read of a status register returns its value from before the read and clears it.
- R6: When an alarm change and a read of that channel's status register meet at the same edge, the bit of the new change is set after the read.
- R7: The inactivity alarm, status and alarm-register bit 0, is declared after 128 consecutive bit periods in which neither monitor line of the channel carried a pulse. The periods are counted after the one-cycle input register. A pulse on either line restarts the count.
- R8: The inactivity alarm clears at the first pulse seen after it was declared.
- R9: The alarm register shows bit 0 inactivity, bit 1 receive LOS, bit 2 loss of lock, bit 4 analog LOS, bit 5 digital LOS and bit 6 pattern detector out of sync. Each bit is the input registered once. Bits 3 and 7 read 0.
- R10: `irq` is high exactly when, in some channel, a status bit and its matching enable bit are both set.
- R11: Writes to status, alarm or unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tmon_pos | input | NCH | Positive transmit monitor line, one per channel |
| tmon_neg | input | NCH | Negative transmit monitor line, one per channel |
| rx_los | input | NCH | Receive loss of signal, per channel |
| rx_lol | input | NCH | Receive loss of lock, per channel |
| ana_los | input | NCH | Analog LOS indication, per channel |
| dig_los | input | NCH | Digital LOS indication, per channel |
| prbs_unsync | input | NCH | Pattern detector out of sync, per channel |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Active-high interrupt |

## Verification
The status logic is driven with rising and then falling alarm edges, so a detector that reacts to one direction only is exposed. A change timed onto the same edge as a status read shows whether clear or set takes priority. The inactivity monitor is stopped once with pulses on the positive line and once with a single restarting pulse on the negative line, and it is read at the 128th and the 129th period after the last pulse, which catches a count that is one too short or one too long. Enable patterns are mixed across channels and written to read-only or unmapped addresses, to show that `irq` follows only enabled bits and that stray writes change nothing.

// File: rtl/lair_pkg.sv
package lair_pkg;
    localparam int DATA_W     = 8;
    localparam int NSRC       = 3;
    localparam int SRC_NOACT  = 0;
    localparam int SRC_RLOS   = 1;
    localparam int SRC_RLOL   = 2;
    localparam int BIT_ALOS   = 4;
    localparam int BIT_DLOS   = 5;
    localparam int BIT_PRBS   = 6;

    typedef enum logic [0:0] {
        MON_LIVE   = 1'b0,
        MON_SILENT = 1'b1
    } mon_state_t;
endpackage

// File: rtl/lair_activity_mon.sv
module lair_activity_mon #(
    parameter int QUIET_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_pos,
    input  logic line_neg,
    output logic no_act
);
    import lair_pkg::*;

    localparam int CNT_W = $clog2(QUIET_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUIET_LEN - 1);

    mon_state_t       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= line_pos | line_neg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MON_LIVE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            MON_LIVE: begin
                if (pulse_q) begin
                    cnt_n = '0;
                end else if (cnt == LAST) begin
                    state_n = MON_SILENT;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            MON_SILENT: begin
                cnt_n = '0;
                if (pulse_q) state_n = MON_LIVE;
            end
            default: begin
                state_n = MON_LIVE;
                cnt_n   = '0;
            end
        endcase
    end

    always_comb begin
        no_act = (state == MON_SILENT);
    end
endmodule

// File: rtl/lair_chan_regs.sv
module lair_chan_regs
    import lair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              no_act,
    input  logic              rx_los,
    input  logic              rx_lol,
    input  logic              ana_los,
    input  logic              dig_los,
    input  logic              prbs_unsync,
    input  logic              wr_ena,
    input  logic [NSRC-1:0]   wdata,
    input  logic              rd_stat,
    output logic [NSRC-1:0]   ena,
    output logic [NSRC-1:0]   stat,
    output logic [NSRC-1:0]   alm_now,
    output logic [DATA_W-1:0] alm_byte
);
    logic            rlos_q, rlol_q, alos_q, dlos_q, prbs_q;
    logic [NSRC-1:0] alm_prev, chg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rlos_q <= 1'b0;
            rlol_q <= 1'b0;
            alos_q <= 1'b0;
            dlos_q <= 1'b0;
            prbs_q <= 1'b0;
        end else begin
            rlos_q <= rx_los;
            rlol_q <= rx_lol;
            alos_q <= ana_los;
            dlos_q <= dig_los;
            prbs_q <= prbs_unsync;
        end
    end

    always_comb begin
        alm_now            = '0;
        alm_now[SRC_NOACT] = no_act;
        alm_now[SRC_RLOS]  = rlos_q;
        alm_now[SRC_RLOL]  = rlol_q;
        chg                = alm_now ^ alm_prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena      <= '0;
            stat     <= '0;
            alm_prev <= '0;
        end else begin
            if (wr_ena) ena <= wdata;
            stat     <= (rd_stat ? '0 : stat) | chg;
            alm_prev <= alm_now;
        end
    end

    always_comb begin
        alm_byte               = '0;
        alm_byte[NSRC-1:0]     = alm_now;
        alm_byte[BIT_ALOS]     = alos_q;
        alm_byte[BIT_DLOS]     = dlos_q;
        alm_byte[BIT_PRBS]     = prbs_q;
    end
endmodule

// File: rtl/lair_bus_port.sv
module lair_bus_port
    import lair_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int ADDR_W    = 8,
    parameter int CH_BASE   = 1,
    parameter int CH_STRIDE = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr,
    input  logic                        rd,
    input  logic [NCH-1:0][NSRC-1:0]    ena_all,
    input  logic [NCH-1:0][NSRC-1:0]    stat_all,
    input  logic [NCH-1:0][DATA_W-1:0]  alm_all,
    output logic [NCH-1:0]              wr_ena,
    output logic [NCH-1:0]              rd_stat,
    output logic [DATA_W-1:0]           rdata
);
    localparam int PAD_W = DATA_W - NSRC;

    logic [NCH-1:0]    hit_ena, hit_stat, hit_alm;
    logic [DATA_W-1:0] rd_val;

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(CH_BASE + c * CH_STRIDE);
        localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(CH_BASE + c * CH_STRIDE + 1);
        localparam logic [ADDR_W-1:0] A_ALM  = ADDR_W'(CH_BASE + c * CH_STRIDE + 2);
        assign hit_ena[c]  = (addr == A_ENA);
        assign hit_stat[c] = (addr == A_STAT);
        assign hit_alm[c]  = (addr == A_ALM);
        assign wr_ena[c]   = wr & hit_ena[c];
        assign rd_stat[c]  = rd & hit_stat[c];
    end

    always_comb begin
        rd_val = '0;
        for (int c = 0; c < NCH; c++) begin
            if (hit_ena[c])  rd_val = {{PAD_W{1'b0}}, ena_all[c]};
            if (hit_stat[c]) rd_val = {{PAD_W{1'b0}}, stat_all[c]};
            if (hit_alm[c])  rd_val = alm_all[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_val;
    end
endmodule

// File: rtl/lair_alarm_bank.sv
module lair_alarm_bank
    import lair_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int ADDR_W    = 8,
    parameter int CH_BASE   = 1,
    parameter int CH_STRIDE = 8,
    parameter int QUIET_LEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    tmon_pos,
    input  logic [NCH-1:0]    tmon_neg,
    input  logic [NCH-1:0]    rx_los,
    input  logic [NCH-1:0]    rx_lol,
    input  logic [NCH-1:0]    ana_los,
    input  logic [NCH-1:0]    dig_los,
    input  logic [NCH-1:0]    prbs_unsync,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [NCH-1:0][NSRC-1:0]   ena_all, stat_all, alm_all;
    logic [NCH-1:0][DATA_W-1:0] alm_bytes;
    logic [NCH-1:0]             wr_ena, rd_stat, no_act;
    logic                       unused_wbits;

    assign unused_wbits = ^bus_wdata[DATA_W-1:NSRC];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lair_activity_mon #(.QUIET_LEN(QUIET_LEN)) mon_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_pos (tmon_pos[c]),
            .line_neg (tmon_neg[c]),
            .no_act   (no_act[c])
        );

        lair_chan_regs regs_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .no_act      (no_act[c]),
            .rx_los      (rx_los[c]),
            .rx_lol      (rx_lol[c]),
            .ana_los     (ana_los[c]),
            .dig_los     (dig_los[c]),
            .prbs_unsync (prbs_unsync[c]),
            .wr_ena      (wr_ena[c]),
            .wdata       (bus_wdata[NSRC-1:0]),
            .rd_stat     (rd_stat[c]),
            .ena         (ena_all[c]),
            .stat        (stat_all[c]),
            .alm_now     (alm_all[c]),
            .alm_byte    (alm_bytes[c])
        );
    end

    lair_bus_port #(
        .NCH       (NCH),
        .ADDR_W    (ADDR_W),
        .CH_BASE   (CH_BASE),
        .CH_STRIDE (CH_STRIDE)
    ) bus_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .ena_all  (ena_all),
        .stat_all (stat_all),
        .alm_all  (alm_bytes),
        .wr_ena   (wr_ena),
        .rd_stat  (rd_stat),
        .rdata    (bus_rdata)
    );

    always_comb begin
        irq = |(ena_all & stat_all);
    end
endmodule

// File: rtl/lair_alarm_bank_chk.sv
module lair_alarm_bank_chk
    import lair_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int ADDR_W    = 8,
    parameter int CH_BASE   = 1,
    parameter int CH_STRIDE = 8,
    parameter int QUIET_LEN = 128
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NCH-1:0]           tmon_pos,
    input logic [NCH-1:0]           tmon_neg,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_rd,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic                     irq,
    input logic [NCH-1:0][NSRC-1:0] alm_all,
    input logic [NCH-1:0][NSRC-1:0] stat_all
);
    localparam int QW = $clog2(QUIET_LEN + 1);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && bus_rdata == '0));

    a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|stat_all));

    for (genvar c = 0; c < NCH; c++) begin : g_ck
        localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(CH_BASE + c * CH_STRIDE + 1);
        logic          pls_d;
        logic [QW-1:0] quiet;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pls_d <= 1'b0;
                quiet <= '0;
            end else begin
                pls_d <= tmon_pos[c] | tmon_neg[c];
                if (pls_d)                     quiet <= '0;
                else if (quiet != QW'(QUIET_LEN)) quiet <= quiet + 1'b1;
            end
        end

        // R4 and R6: every change lands in status whatever the bus does
        a_r4_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((stat_all[c] & ($past(alm_all[c]) ^ $past(alm_all[c], 2)))
                      == ($past(alm_all[c]) ^ $past(alm_all[c], 2))));

        a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr == A_STAT) |=>
            (stat_all[c] == ($past(alm_all[c]) ^ $past(alm_all[c], 2))));

        a_r7_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alm_all[c][SRC_NOACT]) |-> (quiet >= QW'(QUIET_LEN)));

        a_r8_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (alm_all[c][SRC_NOACT] && pls_d) |=> !alm_all[c][SRC_NOACT]);
    end
endmodule

bind lair_alarm_bank lair_alarm_bank_chk #(
    .NCH       (NCH),
    .ADDR_W    (ADDR_W),
    .CH_BASE   (CH_BASE),
    .CH_STRIDE (CH_STRIDE),
    .QUIET_LEN (QUIET_LEN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmon_pos  (tmon_pos),
    .tmon_neg  (tmon_neg),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .alm_all   (alm_all),
    .stat_all  (stat_all)
);

// File: tb/lair_alarm_bank_tb_top.sv
`timescale 1ns/1ps
module lair_alarm_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] tmon_pos, tmon_neg, rx_los, rx_lol, ana_los, dig_los, prbs_unsync;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic       bus_wr, bus_rd, irq;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done  = 0;

    always #10 clk = ~clk;

    lair_alarm_bank dut_i (
        .clk(clk), .rst_n(rst_n), .tmon_pos(tmon_pos), .tmon_neg(tmon_neg),
        .rx_los(rx_los), .rx_lol(rx_lol), .ana_los(ana_los), .dig_los(dig_los),
        .prbs_unsync(prbs_unsync), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd   = 1'b0;
        chk8(tag, bus_rdata, exp);
    endtask

    task automatic rd_drop(input logic [7:0] a);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic clear_all();
        tick(3);
        rd_drop(8'h02);
        rd_drop(8'h0A);
    endtask

    task automatic t_reset();
        chk8("R1 irq", {7'b0, irq}, 8'h00);
        rd_chk("R1 ena0",  8'h01, 8'h00);
        rd_chk("R1 stat0", 8'h02, 8'h00);
        rd_chk("R1 alm0",  8'h03, 8'h00);
        rd_chk("R1 ena1",  8'h09, 8'h00);
        rd_chk("R1 stat1", 8'h0A, 8'h00);
        rd_chk("R1 alm1",  8'h0B, 8'h00);
    endtask

    task automatic t_map();
        wr(8'h01, 8'hFF);
        rd_chk("R3 reserved bits read zero", 8'h01, 8'h07);
        wr(8'h09, 8'h05);
        rd_chk("R3 ena1 stored", 8'h09, 8'h05);
        rd_chk("R2 ena0 separate", 8'h01, 8'h07);
        rd_chk("R2 unmapped 0x00", 8'h00, 8'h00);
        rd_chk("R2 unmapped 0x04", 8'h04, 8'h00);
        rd_chk("R2 unmapped 0x08", 8'h08, 8'h00);
        rd_chk("R2 unmapped 0x11", 8'h11, 8'h00);
    endtask

    task automatic t_ignored();
        wr(8'h02, 8'hFF);
        wr(8'h0A, 8'hFF);
        wr(8'h03, 8'hFF);
        wr(8'h04, 8'hFF);
        wr(8'h0C, 8'hFF);
        rd_chk("R11 stat0 unchanged", 8'h02, 8'h00);
        rd_chk("R11 stat1 unchanged", 8'h0A, 8'h00);
        rd_chk("R11 alm0 unchanged",  8'h03, 8'h00);
        rd_chk("R11 ena0 unchanged",  8'h01, 8'h07);
        rd_chk("R11 ena1 unchanged",  8'h09, 8'h05);
        chk8("R11 irq low", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_status();
        clear_all();
        rx_los[0] = 1'b1;
        tick(2);
        rd_chk("R4 rise sets bit1", 8'h02, 8'h02);
        rd_chk("R5 read cleared", 8'h02, 8'h00);
        rx_los[0] = 1'b0;
        tick(2);
        rd_chk("R4 fall sets bit1", 8'h02, 8'h02);
        rx_lol[0] = 1'b1;
        tick(1);
        rd_chk("R6 read at change edge", 8'h02, 8'h00);
        rd_chk("R6 change won over clear", 8'h02, 8'h04);
        rx_lol[0] = 1'b0;
        clear_all();
    endtask

    task automatic t_layout();
        rx_los[1] = 1'b1; ana_los[1] = 1'b1; prbs_unsync[1] = 1'b1;
        tick(1);
        rd_chk("R9 alm1 los/ana/prbs", 8'h0B, 8'h52);
        rx_los[1] = 1'b0; ana_los[1] = 1'b0; prbs_unsync[1] = 1'b0;
        rx_lol[1] = 1'b1; dig_los[1] = 1'b1;
        tick(1);
        rd_chk("R9 alm1 lol/dig", 8'h0B, 8'h24);
        rd_chk("R9 alm0 untouched", 8'h03, 8'h00);
        rx_lol[1] = 1'b0; dig_los[1] = 1'b0;
        clear_all();
    endtask

    task automatic t_irq();
        wr(8'h01, 8'h00);
        wr(8'h09, 8'h04);
        rx_lol[1] = 1'b1;
        tick(2);
        chk8("R10 enabled lol1 raises irq", {7'b0, irq}, 8'h01);
        rd_drop(8'h0A);
        chk8("R10 irq drops after clear", {7'b0, irq}, 8'h00);
        rx_los[0] = 1'b1;
        tick(2);
        chk8("R10 disabled los0 no irq", {7'b0, irq}, 8'h00);
        wr(8'h01, 8'h02);
        chk8("R10 enabling los0 raises irq", {7'b0, irq}, 8'h01);
        rx_los[0] = 1'b0; rx_lol[1] = 1'b0;
        wr(8'h01, 8'h00);
        wr(8'h09, 8'h00);
        clear_all();
    endtask

    task automatic t_noact();
        tmon_pos[0] = 1'b1;
        tick(1);
        tmon_pos[0] = 1'b0;
        tick(128);
        rd_chk("R7 no alarm at 128th period", 8'h03, 8'h00);
        rd_chk("R7 alarm after 128 periods", 8'h03, 8'h01);
        rd_chk("R7 alarm0 only", 8'h0B, 8'h00);
        rd_chk("R7 status bit0 set", 8'h02, 8'h01);
        tmon_pos[0] = 1'b1;
        tick(1);
        tmon_pos[0] = 1'b0;
        tick(1);
        rd_chk("R8 first pulse clears", 8'h03, 8'h00);
        tick(60);
        tmon_neg[0] = 1'b1;
        tick(1);
        tmon_neg[0] = 1'b0;
        tick(128);
        rd_chk("R7 neg pulse restarted count", 8'h03, 8'h00);
        rd_chk("R7 alarm after restart", 8'h03, 8'h01);
        tmon_pos[0] = 1'b1;
        tick(2);
        rd_chk("R8 cleared again", 8'h03, 8'h00);
        clear_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        tmon_pos = 2'b11; tmon_neg = 2'b00;
        rx_los = '0; rx_lol = '0; ana_los = '0; dig_los = '0; prbs_unsync = '0;
        bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_map();
        t_ignored();
        t_status();
        t_layout();
        t_irq();
        t_noact();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule